// File: doc/BRIEF.md
# Ping-Pong Streaming Matrix Transpose

This block sits between the row pass and the column pass of a two-dimensional transform. It accepts a square matrix of complex samples, one sample per clock, in row-major order, and returns the same matrix in column-major order as an unbroken stream. Two full-matrix memory banks take turns. The incoming matrix is written into one bank while the previous matrix is read out of the other bank through a transposing address generator. The roles swap each time the last sample of a matrix has been written.

The matrix side length is `2**LOG2_DIM`. A 256×256 transform uses `LOG2_DIM = 8`. The default of 4 keeps the elaborated memories small. Each sample is stored as one memory word that holds the real part in its upper half and the imaginary part in its lower half.

The write side is a counter that advances only on accepted samples. The read side is a two-state machine. It waits in `RD_IDLE`, takes `IDLE->STREAM` when a matrix completes, and walks all `DIM*DIM` column-major addresses in `RD_STREAM`. At the last address it takes `STREAM->IDLE`, or `STREAM->STREAM` (restart on the other bank) when the next matrix completes in that same cycle. Each bank has its own write enable and read enable. A registered select picks which bank drives the output.

Top module: `transpose_pingpong`

## Requirements
- R1: While reset is asserted, and afterwards until a full matrix has been stored, `out_valid` and `out_first` are low.
- R2: Within one output matrix, the k-th valid output (k counted from 0) is the input element at row `k mod DIM` and column `k div DIM`. The element at row r and column c is the sample that arrived at position `r*DIM + c` of the row-major input matrix.
- R3: The first output of a matrix is presented in the clock cycle after the cycle in which that matrix's last sample is accepted.
- R4: With `in_valid` held high, `out_valid` stays high for exactly `DIM*DIM` cycles per matrix, and back-to-back matrices give an output stream with no gap.
- R5: `out_first` is high for exactly one cycle per output matrix, together with element (0,0), and only while `out_valid` is high.
- R6: When input stalls, writing pauses. Each completed matrix is still output exactly once with exactly `DIM*DIM` samples, and `out_valid` stays low between output matrices.
- R7: A sample accepted with `in_first` high is stored as element (0,0) of a new matrix. Any partially written matrix before it is discarded and never output.
- R8: Banks alternate by matrix. The bank being written is never the bank being read, and a matrix being read is never cut short by the next one.
- R9: When `in_valid` is low, `in_first`, `in_re` and `in_im` have no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_first | input | 1 | Input sample is element (0,0) of a matrix |
| in_re | input | PART_W | Real part of the input sample |
| in_im | input | PART_W | Imaginary part of the input sample |
| out_valid | output | 1 | Output sample present this cycle |
| out_first | output | 1 | Output sample is element (0,0) |
| out_re | output | PART_W | Real part of the output sample |
| out_im | output | PART_W | Imaginary part of the output sample |

## Verification
The embedded assertions check several properties on every cycle:
- the first-sample flag stays inside a valid stream and opens each stream;
- the bank being written differs from the bank being read;
- the bank pointer moves only at a matrix boundary;
- the read counter climbs one step per streaming cycle;
- a new matrix never preempts a read in progress.

Only the bench's scenarios can show the rest, by comparing each cycle against a behavioural queue model:
- that the data actually emerges in column-major order;
- the one-cycle latency after the last write;
- the exact run length under continuous input;
- that stalls, stray data on idle cycles and mid-matrix resynchronisation lose or duplicate nothing.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic [0:0] {
        RD_IDLE   = 1'b0,
        RD_STREAM = 1'b1
    } rd_state_t;

endpackage

// File: rtl/tp_wr_ctrl.sv
module tp_wr_ctrl #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_bank,
    output logic              mat_done
);

    logic [ADDR_W-1:0] cnt;

    // A flagged first sample realigns the matrix to element (0,0).
    assign wr_addr  = in_first ? '0 : cnt;
    assign wr_en    = in_valid;
    assign mat_done = in_valid && (wr_addr == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            wr_bank <= 1'b0;
        end else if (in_valid) begin
            cnt <= wr_addr + 1'b1;
            if (mat_done) begin
                wr_bank <= ~wr_bank;
            end
        end
    end

    // R8
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mat_done |=> $stable(wr_bank));

    // R8
    bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mat_done |=> (wr_bank != $past(wr_bank)));

endmodule

// File: rtl/tp_rd_ctrl.sv
module tp_rd_ctrl
    import tp_pkg::*;
#(
    parameter int LOG2_DIM = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    start_bank,
    output logic                    rd_en,
    output logic                    rd_bank,
    output logic [2*LOG2_DIM-1:0]   rd_addr,
    output logic                    rd_first
);

    localparam int ADDR_W = 2 * LOG2_DIM;

    rd_state_t         state, state_nx;
    logic [ADDR_W-1:0] cnt;
    logic              last;

    assign last = (cnt == '1);

    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE:   if (start)          state_nx = RD_STREAM;
            RD_STREAM: if (last && !start) state_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rd_bank <= 1'b0;
        end else if (start) begin
            cnt     <= '0;
            rd_bank <= start_bank;
        end else if (state == RD_STREAM) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Column-major walk: the low counter field picks the row, the high field the column.
    assign rd_en    = (state == RD_STREAM);
    assign rd_addr  = {cnt[LOG2_DIM-1:0], cnt[ADDR_W-1:LOG2_DIM]};
    assign rd_first = rd_en && (cnt == '0);

    // R4
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_STREAM && !last && !start) |=> (cnt == ADDR_W'($past(cnt) + 1'b1)));

    // R8
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == RD_STREAM) |-> last);

endmodule

// File: rtl/tp_bank.sv
module tp_bank #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/transpose_pingpong.sv
module transpose_pingpong #(
    parameter int LOG2_DIM = 4,
    parameter int PART_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [PART_W-1:0] in_re,
    input  logic [PART_W-1:0] in_im,
    output logic              out_valid,
    output logic              out_first,
    output logic [PART_W-1:0] out_re,
    output logic [PART_W-1:0] out_im
);

    localparam int ADDR_W = 2 * LOG2_DIM;
    localparam int WORD_W = 2 * PART_W;

    logic              wr_en, wr_bank, mat_done;
    logic [ADDR_W-1:0] wr_addr;
    logic              rd_en, rd_bank, rd_first;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rdata [2];
    logic [WORD_W-1:0] word;
    logic              sel_q;

    tp_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_bank  (wr_bank),
        .mat_done (mat_done)
    );

    tp_rd_ctrl #(.LOG2_DIM(LOG2_DIM)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (mat_done),
        .start_bank (wr_bank),
        .rd_en      (rd_en),
        .rd_bank    (rd_bank),
        .rd_addr    (rd_addr),
        .rd_first   (rd_first)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        tp_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
            .clk   (clk),
            .we    (wr_en && (wr_bank == 1'(b))),
            .waddr (wr_addr),
            .wdata ({in_re, in_im}),
            .re    (rd_en && (rd_bank == 1'(b))),
            .raddr (rd_addr),
            .rdata (rdata[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            sel_q     <= 1'b0;
        end else begin
            out_valid <= rd_en;
            out_first <= rd_first;
            sel_q     <= rd_bank;
        end
    end

    assign word   = sel_q ? rdata[1] : rdata[0];
    assign out_re = word[WORD_W-1:PART_W];
    assign out_im = word[PART_W-1:0];

    // R5
    first_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid);

    // R5
    stream_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_first);

    // R8
    bank_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |-> (wr_bank != rd_bank));

endmodule

// File: tb/sim_transpose_pingpong.sv
module sim_transpose_pingpong;

    localparam int LOG2_DIM = 4;
    localparam int PW       = 16;
    localparam int DIM      = 1 << LOG2_DIM;
    localparam int N2       = DIM * DIM;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_first = 1'b0;
    logic [PW-1:0] in_re = '0, in_im = '0;
    logic          out_valid, out_first;
    logic [PW-1:0] out_re, out_im;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    transpose_pingpong #(.LOG2_DIM(LOG2_DIM), .PART_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_first(out_first),
        .out_re(out_re), .out_im(out_im)
    );

    // Behavioural reference: one queue of {first, word}.
    logic [2*PW:0]   expq [$];
    logic [2*PW-1:0] cur  [N2];
    int              idx = 0;
    bit              exp_v = 0, exp_f = 0;
    logic [2*PW-1:0] exp_d = '0;
    int              pushed = 0, seen = 0;
    int              run = 0, last_run = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            expq.delete();
            idx   = 0;
            exp_v = 0;
            exp_f = 0;
        end else begin
            exp_v = 0;
            exp_f = 0;
            if (expq.size() > 0) begin
                logic [2*PW:0] e;
                e = expq.pop_front();
                exp_v = 1;
                exp_f = e[2*PW];
                exp_d = e[2*PW-1:0];
            end
            if (in_valid) begin
                if (in_first) idx = 0;
                cur[idx] = {in_re, in_im};
                if (idx == N2 - 1) begin
                    for (int k = 0; k < N2; k++) begin
                        expq.push_back({(k == 0), cur[(k % DIM) * DIM + (k / DIM)]});
                        pushed++;
                    end
                    idx = 0;
                end else begin
                    idx++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(out_valid == exp_v, "R4 valid timing", 64'(out_valid), 64'(exp_v));
            chk(out_first == exp_f, "R5 first flag", 64'(out_first), 64'(exp_f));
            if (exp_v)
                chk({out_re, out_im} == exp_d, "R2 column-major data", 64'({out_re, out_im}), 64'(exp_d));
            if (out_valid) begin
                seen++;
                run++;
            end else if (run != 0) begin
                last_run = run;
                run = 0;
            end
        end
    end

    function automatic logic [2*PW-1:0] pat(input int m, input int i);
        return {PW'(m * 4099 + i * 7 + 1), PW'(16'hA000 ^ (m * 313 + i))};
    endfunction

    task automatic send(input logic [2*PW-1:0] w, input bit first);
        in_valid = 1'b1;
        in_first = first;
        {in_re, in_im} = w;
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
    endtask

    task automatic idle_junk(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            in_first = 1'($urandom_range(0, 1));   // R9: ignored while idle
            in_re = PW'($urandom);
            in_im = PW'($urandom);
            @(negedge clk);
        end
        in_first = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_first == 0, "R1 outputs low in reset", 64'({out_valid, out_first}), 64'(0));
        rst_n = 1'b1;
        idle_junk(5);
        chk(out_valid == 0, "R1 idle after reset", 64'(out_valid), 64'(0));

        // Scenario A: three back-to-back matrices, continuous (R2, R3, R4)
        for (int m = 0; m < 3; m++) begin
            for (int i = 0; i < N2; i++) begin
                send(pat(m, i), i == 0);
                if (m == 0 && i == N2 - 1)
                    chk(out_valid == 0, "R3 no output before full matrix", 64'(out_valid), 64'(0));
                if (m == 1 && i == 0)
                    chk(out_valid && out_first && {out_re, out_im} == pat(0, 0),
                        "R3 first output one cycle after last write",
                        64'({out_valid, out_first}), 64'(3));
            end
        end
        idle_junk(N2 + 4);
        chk(last_run == 3 * N2, "R4 unbroken run length", 64'(last_run), 64'(3 * N2));

        // Scenario B: random stalls with junk on idle cycles (R6, R9)
        for (int m = 3; m < 6; m++) begin
            for (int i = 0; i < N2; i++) begin
                if ($urandom_range(0, 2) == 0) idle_junk($urandom_range(1, 3));
                send(pat(m, i), i == 0);
            end
            if (m == 4) idle_junk(N2 + 10);   // long gap at a matrix boundary
        end
        idle_junk(N2 + 4);
        chk(last_run == N2, "R6 exact count after stalled matrix", 64'(last_run), 64'(N2));
        chk(seen == pushed, "R6 nothing lost or duplicated", 64'(seen), 64'(pushed));

        // Scenario C: partial matrix then resync with in_first (R7)
        for (int i = 0; i < 40; i++) send(pat(9, i), i == 0);
        for (int i = 0; i < N2; i++) send(pat(10, i), i == 0);
        idle_junk(N2 + 4);
        chk(last_run == N2, "R7 discarded partial matrix", 64'(last_run), 64'(N2));
        chk(seen == pushed, "R7 output count after resync", 64'(seen), 64'(pushed));

        // Scenario D: resync exactly at last position, then continuous pair (R7, R4)
        for (int i = 0; i < N2 - 1; i++) send(pat(11, i), i == 0);
        for (int m = 12; m < 14; m++)
            for (int i = 0; i < N2; i++) send(pat(m, i), i == 0);
        idle_junk(N2 + 4);
        chk(last_run == 2 * N2, "R4 run after resync at boundary", 64'(last_run), 64'(2 * N2));
        chk(expq.size() == 0 && out_valid == 0, "R6 drained and idle", 64'(expq.size()), 64'(0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule